// File: doc/BRIEF.md
# Serial EEPROM Command Master (3-wire, byte organization)

This block lets on-chip logic use a 3-wire serial EEPROM that is organized as 256 bytes. Logic upstream presents one command at a time on a parallel port: a command code, a byte address and a data byte, with a valid/ready handshake. The master raises chip select and generates the serial clock from a divided system clock. It shifts the command frame out on the data-in wire and collects bits from the data-out wire. When the command has finished it reports completion with a one-cycle done pulse, returning the data byte after a read.

Each frame has the length its command calls for. A read clocks in eight data bits after the header and drops the leading zero that the memory sends first. Chip select always stays low for at least a set number of clocks between frames. After a command that programs the array, the master drops chip select and waits out that gap. It then raises chip select again, with the clock held low, and watches the data-out wire until the memory reports ready. If ready never arrives within a bounded number of polls, the master flags an error and closes the command.

Top module: `uwire_eeprom_host`

## Requirements
- R1: Under reset and afterwards in idle, `sr_cs` and `sr_sk` are low, `cmd_ready` is high and `done` is low.
- R2: Every frame starts with a 1 bit followed by a 2-bit code, sent MSB first. The codes are 10 read, 01 write and 11 erase. Code 00 is followed by a 2-bit sub-code: 11 enable, 00 disable, 10 erase-all, 01 write-all. After code 10, 01 or 11 comes a 0 bit and then the address MSB first. After code 00 the sub-code is padded with zeros up to the same 9-bit field.
- R3: Erase, enable, disable and erase-all frames take 12 rising edges of `sr_sk`. Write and write-all frames take 20, where the last 8 carry the data byte MSB first. A read frame takes 12 edges of header and then 8 edges for the returned data, 20 in total.
- R4: `sr_sk` is low whenever `sr_cs` is low. `sr_di` does not change while `sr_sk` is high. Consecutive rising edges of `sr_sk` within a frame are 2*HALF_DIV clocks apart.
- R5: `sr_do` is sampled on the falling edges of `sr_sk`. On a read, the bit sampled after the 12th rising edge is discarded, and the next 8 samples form `rd_data`, MSB first.
- R6: Between any two periods with `sr_cs` high, `sr_cs` stays low for at least GAP_CYC clocks. This applies both between commands and between a frame and its ready poll.
- R7: After write, erase, erase-all and write-all, `sr_cs` is raised a second time with `sr_sk` held low. `done` is not given until `sr_do` has been sampled as 1 during that second period.
- R8: If no ready sample arrives within POLL_LIMIT+1 polls, spaced HALF_DIV clocks apart, the command ends with `err` high alongside `done`. `err` clears when the next command is accepted.
- R9: A command is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is then low until the cycle in which the one-cycle `done` pulse appears.
- R10: Read, enable and disable use a single chip-select period with no ready poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High when a command can be taken |
| cmd_op | input | 3 | 0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 erase-all, 6 write-all (7 acts as disable) |
| cmd_addr | input | 8 | Byte address |
| cmd_wdata | input | 8 | Data byte for write and write-all |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte from the last read, valid with `done` |
| err | output | 1 | Ready poll timed out on the last command |
| sr_cs | output | 1 | Memory chip select |
| sr_sk | output | 1 | Memory serial clock |
| sr_di | output | 1 | Serial data toward the memory |
| sr_do | input | 1 | Serial data and ready status from the memory |

## Verification
The bench aims at the points where a wrong design goes quietly wrong against a behavioural memory model. It targets reads at addresses 0x00 and 0xFF, where a one-bit slip in sampling either returns a byte shifted by one or keeps the dummy zero as the top bit. It compares the frame length of each command class with its code. A master that sends 20 clocks where 12 are due, or mixes up the sub-codes, leaves the model memory at odds with the bench's reference copy. It also gives the model a busy time of random length and counts chip-select periods, so that a master that skips the poll or raises done before ready is caught. A ready line held at busy must end in an error that does not linger into the next command.

// File: rtl/uwire_pkg.sv
// Shared definitions for the serial EEPROM command master.
// Holds the command codes, frame geometry and the helpers that turn a
// command into its serial frame. Byte organization only.
package uwire_pkg;

    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned DATA_W  = 8;
    // start bit + 2-bit code + don't-care + address
    localparam int unsigned HDR_W   = 1 + 2 + 1 + ADDR_W;
    localparam int unsigned FRAME_W = HDR_W + DATA_W;
    localparam int unsigned BITS_W  = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_WEN   = 3'd3,
        OP_WDS   = 3'd4,
        OP_ERAL  = 3'd5,
        OP_WRAL  = 3'd6
    } uw_op_e;

    typedef logic [FRAME_W-1:0] uw_frame_t;

    // Left-aligned frame; shorter frames carry zeros in the tail.
    function automatic uw_frame_t build_frame(uw_op_e op,
                                              logic [ADDR_W-1:0] addr,
                                              logic [DATA_W-1:0] data);
        logic [1:0]        code;
        logic [ADDR_W:0]   field;
        logic [DATA_W-1:0] tail;
        code  = 2'b00;
        field = '0;
        tail  = '0;
        case (op)
            OP_READ:  begin code = 2'b10; field = {1'b0, addr}; end
            OP_WRITE: begin code = 2'b01; field = {1'b0, addr}; tail = data; end
            OP_ERASE: begin code = 2'b11; field = {1'b0, addr}; end
            OP_WEN:   field = {2'b11, {(ADDR_W-1){1'b0}}};
            OP_ERAL:  field = {2'b10, {(ADDR_W-1){1'b0}}};
            OP_WRAL:  begin field = {2'b01, {(ADDR_W-1){1'b0}}}; tail = data; end
            default:  field = '0;
        endcase
        return {1'b1, code, field, tail};
    endfunction

    // Number of serial clocks the command occupies.
    function automatic logic [BITS_W-1:0] frame_len(uw_op_e op);
        case (op)
            OP_READ, OP_WRITE, OP_WRAL: return BITS_W'(FRAME_W);
            default:                    return BITS_W'(HDR_W);
        endcase
    endfunction

    // Commands that start a self-timed program cycle.
    function automatic logic needs_poll(uw_op_e op);
        case (op)
            OP_WRITE, OP_ERASE, OP_ERAL, OP_WRAL: return 1'b1;
            default:                              return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uwire_tick.sv
// Strobe generator: pulses tick once every DIV clocks while run is high.
// Assumes DIV >= 1. The count restarts from zero whenever run is low, so the
// first strobe comes a full DIV clocks after run rises.
module uwire_tick #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned W = $clog2(DIV + 1);

    logic [W-1:0] cnt_q;

    assign tick = run && (cnt_q == W'(DIV - 1));

    // Count clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/uwire_down_cnt.sv
// Loadable down counter that stops at zero.
// A load has priority over a decrement in the same cycle.
module uwire_down_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero,
    output logic         one
);
    logic [W-1:0] val_q;

    assign zero = (val_q == '0);
    assign one  = (val_q == W'(1));

    // Load or count down, saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             val_q <= '0;
        else if (load)          val_q <= load_val;
        else if (dec && !zero)  val_q <= val_q - 1'b1;
    end
endmodule

// File: rtl/uwire_shift_io.sv
// Paired shift registers for the serial wires. The transmit register is
// loaded in parallel and presents its MSB. On each step it moves one place
// left while the receive register takes in one sample at its LSB.
module uwire_shift_io #(
    parameter int unsigned TX_W = 20,
    parameter int unsigned RX_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_val,
    input  logic            step,
    input  logic            sin,
    output logic            sout,
    output logic [RX_W-1:0] rx_q
);
    logic [TX_W-1:0] tx_q;

    assign sout = tx_q[TX_W-1];

    // Outgoing bits: parallel load, then shift left one bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n)    tx_q <= '0;
        else if (load) tx_q <= load_val;
        else if (step) tx_q <= {tx_q[TX_W-2:0], 1'b0};
    end

    // Incoming bits: append the sampled line at the LSB on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_q <= '0;
        else if (step) rx_q <= {rx_q[RX_W-2:0], sin};
    end
endmodule

// File: rtl/uwire_eeprom_host.sv
// Serial EEPROM command master, byte organization.
// Accepts one command in idle, sends its frame with SK made from the system
// clock (HALF_DIV clocks per half period), and samples DO on SK falling
// edges. Program commands are followed by a ready poll with CS raised again.
// Each chip-select period is followed by at least GAP_CYC clocks with CS low.
// Assumes sr_do is already synchronous to clk and settled within HALF_DIV.
module uwire_eeprom_host
    import uwire_pkg::*;
#(
    parameter int unsigned HALF_DIV   = 4,
    parameter int unsigned GAP_CYC    = 16,
    parameter int unsigned POLL_LIMIT = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              err,
    output logic              sr_cs,
    output logic              sr_sk,
    output logic              sr_di,
    input  logic              sr_do
);
    localparam int unsigned GAP_W  = $clog2(GAP_CYC + 1);
    localparam int unsigned POLL_W = $clog2(POLL_LIMIT + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP, ST_POLL} st_e;

    st_e               state_q;
    uw_op_e            op_q;
    uw_op_e            op_in;
    logic              cs_q, sk_q, pend_q, done_q, err_q;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] rx_byte;

    logic tick, accept, fall, enter_gap, poll_tick;
    logic gap_zero, gap_one_unused;
    logic poll_zero, poll_one_unused;
    logic bit_zero_unused, bit_one;

    assign op_in     = uw_op_e'(cmd_op);
    assign cmd_ready = (state_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign fall      = (state_q == ST_FRAME) && tick && sk_q;
    assign poll_tick = (state_q == ST_POLL) && tick;
    assign enter_gap = (fall && bit_one) || (poll_tick && (sr_do || poll_zero));

    uwire_tick #(.DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  ((state_q == ST_FRAME) || (state_q == ST_POLL)),
        .tick (tick)
    );

    // Remaining serial clocks in the frame.
    uwire_down_cnt #(.W(BITS_W)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .load_val(frame_len(op_in)),
        .dec     (fall),
        .zero    (bit_zero_unused),
        .one     (bit_one)
    );

    // Clocks of enforced CS-low time.
    uwire_down_cnt #(.W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (enter_gap),
        .load_val(GAP_W'(GAP_CYC)),
        .dec     (state_q == ST_GAP),
        .zero    (gap_zero),
        .one     (gap_one_unused)
    );

    // Polls left before the ready wait is abandoned.
    uwire_down_cnt #(.W(POLL_W)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    ((state_q == ST_GAP) && gap_zero && pend_q),
        .load_val(POLL_W'(POLL_LIMIT)),
        .dec     (poll_tick),
        .zero    (poll_zero),
        .one     (poll_one_unused)
    );

    uwire_shift_io #(.TX_W(FRAME_W), .RX_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .load_val(build_frame(op_in, cmd_addr, cmd_wdata)),
        .step    (fall),
        .sin     (sr_do),
        .sout    (sr_di),
        .rx_q    (rx_byte)
    );

    // Command sequencer: frame, gap, optional poll and gap, then done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_WDS;
            cs_q    <= 1'b0;
            sk_q    <= 1'b0;
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rd_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    op_q    <= op_in;
                    cs_q    <= 1'b1;
                    sk_q    <= 1'b0;
                    err_q   <= 1'b0;
                    state_q <= ST_FRAME;
                end
                ST_FRAME: if (tick) begin
                    sk_q <= !sk_q;
                    if (sk_q && bit_one) begin
                        cs_q    <= 1'b0;
                        pend_q  <= needs_poll(op_q);
                        state_q <= ST_GAP;
                    end
                end
                ST_GAP: if (gap_zero) begin
                    if (pend_q) begin
                        pend_q  <= 1'b0;
                        cs_q    <= 1'b1;
                        state_q <= ST_POLL;
                    end else begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                        if (op_q == OP_READ) rd_q <= rx_byte;
                    end
                end
                ST_POLL: if (tick) begin
                    if (sr_do || poll_zero) begin
                        cs_q    <= 1'b0;
                        state_q <= ST_GAP;
                        if (!sr_do) err_q <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sr_cs   = cs_q;
    assign sr_sk   = sk_q;
    assign done    = done_q;
    assign err     = err_q;
    assign rd_data = rd_q;
endmodule

// File: rtl/uwire_host_chk.sv
// Protocol checker for uwire_eeprom_host, attached with bind.
// Watches the serial wires and the command handshake only.
module uwire_host_chk #(
    parameter int unsigned GAP_CYC = 16
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic done,
    input logic err,
    input logic sr_cs,
    input logic sr_sk,
    input logic sr_di
);
    localparam int unsigned LW = $clog2(GAP_CYC + 2);

    logic [LW-1:0] low_cnt;

    // Count clocks with CS low, saturating at the required gap.
    always_ff @(posedge clk) begin
        if (!rst_n)                       low_cnt <= LW'(GAP_CYC);
        else if (sr_cs)                   low_cnt <= '0;
        else if (low_cnt < LW'(GAP_CYC))  low_cnt <= low_cnt + 1'b1;
    end

    // R1
    idle_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !sr_cs);
    // R4
    sk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_cs |-> !sr_sk);
    // R4
    di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_sk |-> $stable(sr_di));
    // R6
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_cs) |-> (low_cnt >= LW'(GAP_CYC)));
    // R9
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready) |-> done);
    // R8
    err_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !cmd_ready);
endmodule

bind uwire_eeprom_host uwire_host_chk #(.GAP_CYC(GAP_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .done     (done),
    .err      (err),
    .sr_cs    (sr_cs),
    .sr_sk    (sr_sk),
    .sr_di    (sr_di)
);

// File: tb/uwire_eeprom_host_test.sv
// Bench for uwire_eeprom_host: behavioural 256-byte memory model on the
// serial wires, reference copy of its contents, directed and random commands.
module uwire_eeprom_host_test;
    localparam int unsigned HALF = 2;
    localparam int unsigned GAP  = 5;
    localparam int unsigned PLIM = 64;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic       cmd_ready;
    logic [2:0] cmd_op;
    logic [7:0] cmd_addr, cmd_wdata;
    logic       done;
    logic [7:0] rd_data;
    logic       err;
    logic       sr_cs, sr_sk, sr_di, sr_do;

    always #2 clk = ~clk; // 250 MHz

    uwire_eeprom_host #(.HALF_DIV(HALF), .GAP_CYC(GAP), .POLL_LIMIT(PLIM)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .done(done), .rd_data(rd_data), .err(err),
        .sr_cs(sr_cs), .sr_sk(sr_sk), .sr_di(sr_di), .sr_do(sr_do)
    );

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- memory model ----------------
    logic        inited = 1'b0;
    logic        cs_prev = 1'b0;
    logic [19:0] sh = '0;
    logic [11:0] hdr = '0;
    logic        rmode = 1'b0, dout = 1'b0, wen_m = 1'b0;
    logic [7:0]  rbuf = '0;
    logic [7:0]  mem [256];
    int          nbits = 0, sess = 0, m_chk = 0, m_err = 0;
    int unsigned busy_until = 0, fall_cyc = 0, last_rise = 0;
    logic        stuck = 1'b0;

    assign sr_do = rmode ? dout : ((stuck || cyc < busy_until) ? 1'b0 : 1'b1);

    always @(posedge sr_sk or posedge sr_cs or negedge sr_cs) begin
        logic [1:0] op, sub;
        logic [7:0] a, d;
        int explen;
        if (!inited) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
            inited = 1'b1;
        end
        if (sr_cs !== cs_prev) begin
            cs_prev = sr_cs;
            if (sr_cs) begin
                sess++; nbits = 0; rmode = 1'b0;
                m_chk++;
                if (cyc - fall_cyc < GAP) begin
                    m_err++;
                    $display("FAIL R6 cs low gap: got %0d expected >= %0d", cyc - fall_cyc, GAP);
                end
            end else begin
                fall_cyc = cyc; rmode = 1'b0;
                if (nbits > 0) begin
                    op = hdr[10:9]; sub = hdr[8:7]; a = hdr[7:0]; d = sh[7:0];
                    explen = (op == 2'b10 || op == 2'b01 || (op == 2'b00 && sub == 2'b01)) ? 20 : 12;
                    m_chk++;
                    if (nbits != explen || hdr[11] !== 1'b1) begin
                        m_err++;
                        $display("FAIL R3 frame length/start: got %0d expected %0d", nbits, explen);
                    end
                    if (nbits == explen) begin
                        case (op)
                            2'b01: if (wen_m) begin mem[a] = d; busy_until = cyc + 10 + $urandom % 40; end
                            2'b11: if (wen_m) begin mem[a] = 8'hFF; busy_until = cyc + 10 + $urandom % 40; end
                            2'b00: case (sub)
                                2'b11: wen_m = 1'b1;
                                2'b00: wen_m = 1'b0;
                                2'b10: if (wen_m) begin
                                    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
                                    busy_until = cyc + 10 + $urandom % 40;
                                end
                                default: if (wen_m) begin
                                    for (int i = 0; i < 256; i++) mem[i] = d;
                                    busy_until = cyc + 10 + $urandom % 40;
                                end
                            endcase
                            default: ;
                        endcase
                    end
                end
            end
        end else if (sr_cs) begin
            sh = {sh[18:0], sr_di};
            nbits++;
            if (nbits > 1) begin
                m_chk++;
                if (cyc - last_rise != 2 * HALF) begin
                    m_err++;
                    $display("FAIL R4 sk period: got %0d expected %0d", cyc - last_rise, 2 * HALF);
                end
            end
            last_rise = cyc;
            if (nbits == 12) begin
                hdr = sh[11:0];
                if (sh[10:9] == 2'b10) begin rmode = 1'b1; dout = 1'b0; rbuf = mem[sh[7:0]]; end
            end else if (nbits > 12 && rmode) begin
                dout = rbuf[7]; rbuf = {rbuf[6:0], 1'b0};
            end
        end
    end

    // ---------------- checking ----------------
    int   nchk = 0, nerr = 0;
    logic wd = 1'b0;
    logic [7:0] ref_mem [256];
    logic ref_wen = 1'b0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_prog(input logic [2:0] op);
        return op == 3'd1 || op == 3'd2 || op == 3'd5 || op == 3'd6;
    endfunction

    task automatic ref_apply(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
        case (op)
            3'd1: if (ref_wen) ref_mem[a] = d;
            3'd2: if (ref_wen) ref_mem[a] = 8'hFF;
            3'd3: ref_wen = 1'b1;
            3'd4: ref_wen = 1'b0;
            3'd5: if (ref_wen) for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
            3'd6: if (ref_wen) for (int i = 0; i < 256; i++) ref_mem[i] = d;
            default: ;
        endcase
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d,
                           input bit exp_err);
        int s0, guard;
        bit early;
        while (!cmd_ready) @(negedge clk);
        s0 = sess; early = 1'b0;
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9", "ready low after accept", cmd_ready, 0);
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            if (!done && cmd_ready) early = 1'b1;
            guard++;
        end
        chk("R9", "done seen, ready held low", {done, early}, 2'b10);
        chk("R9", "ready with done", cmd_ready, 1);
        chk("R8", "err with done", err, exp_err);
        chk(is_prog(op) ? "R7" : "R10", "chip select periods", sess - s0, is_prog(op) ? 2 : 1);
        if (is_prog(op) && !exp_err)
            chk("R7", "done after ready", cyc >= busy_until, 1);
        ref_apply(op, a, d);
        if (op == 3'd0) chk("R5", "read data", rd_data, ref_mem[a]);
        @(negedge clk);
        chk("R9", "done one cycle", done, 0);
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", nchk + m_chk + int'(wd), nerr + m_err + int'(wd));
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset cs/sk/ready/done", {sr_cs, sr_sk, cmd_ready, done}, 4'b0010);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "idle cs/sk/ready/done", {sr_cs, sr_sk, cmd_ready, done}, 4'b0010);

        run_cmd(3'd0, 8'h10, 8'h00, 1'b0);          // R5 erased read
        run_cmd(3'd1, 8'h05, 8'h3C, 1'b0);          // R2 write while disabled
        run_cmd(3'd0, 8'h05, 8'h00, 1'b0);
        run_cmd(3'd3, 8'h00, 8'h00, 1'b0);          // R2 enable sub-code
        run_cmd(3'd1, 8'h81, 8'h5A, 1'b0);
        run_cmd(3'd0, 8'h81, 8'h00, 1'b0);
        run_cmd(3'd1, 8'h00, 8'h01, 1'b0);          // R5 boundary address and LSB
        run_cmd(3'd1, 8'hFF, 8'h80, 1'b0);          // R5 MSB only
        run_cmd(3'd0, 8'h00, 8'h00, 1'b0);
        run_cmd(3'd0, 8'hFF, 8'h00, 1'b0);

        for (int n = 0; n < 40; n++) begin
            logic [2:0] op;
            op = 3'($urandom % 3);
            run_cmd(op, 8'($urandom), 8'($urandom), 1'b0);
        end

        run_cmd(3'd5, 8'h00, 8'h00, 1'b0);          // R2 erase-all
        for (int n = 0; n < 4; n++) run_cmd(3'd0, 8'($urandom), 8'h00, 1'b0);
        run_cmd(3'd6, 8'h00, 8'hA5, 1'b0);          // R3 write-all carries data
        for (int n = 0; n < 4; n++) run_cmd(3'd0, 8'($urandom), 8'h00, 1'b0);
        run_cmd(3'd4, 8'h00, 8'h00, 1'b0);          // R2 disable
        run_cmd(3'd1, 8'h22, 8'h11, 1'b0);
        run_cmd(3'd0, 8'h22, 8'h00, 1'b0);

        stuck = 1'b1;                               // R8 ready never comes
        run_cmd(3'd2, 8'h22, 8'h00, 1'b1);
        stuck = 1'b0;
        run_cmd(3'd0, 8'h22, 8'h00, 1'b0);          // R8 err cleared

        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
        $display("FAIL watchdog: run did not complete");
        report();
        $finish;
    end
endmodule